// File: doc/BRIEF.md
# Instruction cache valid-bit controller

This block decides, for every instruction fetch, whether a set-associative instruction cache may serve it or whether it has to go to the next level. It also owns the valid bit of every way in every set. Three configuration bits govern it: enable, lock and flash-invalidate. A separate command clears one whole set by index. The tag compare is done outside the block and arrives as a per-way match vector next to the fetch. Line fills from the refill logic arrive as set and way numbers. The valid array can be read through a small observe port.

A hard reset clears the configuration and empties the whole cache. A soft reset clears only the configuration and leaves the cached lines in place. While the cache is disabled, every fetch goes downstream as a single-beat transfer. While it is locked, hits are still served, but misses go out single-beat and fills are refused. The set-invalidate command uses the index alone. It works in every mode, takes one cycle, is never sent to the bus, and makes a fetch to the same set in that cycle miss.

Top module: `icache_ctl`

## Requirements
- R1: While `rst_n` is low and after it rises, every valid bit reads 0 and `cfg_rdata` reads 0.
- R2: A one-cycle `soft_rst` sets `cfg_rdata` to 0 at the next edge and leaves every valid bit unchanged.
- R3: With the enable bit 0, every fetch gives `fetch_hit`=0, `ds_req`=1 and `ds_single`=1, and fills leave the valid bits unchanged.
- R4: With enable=1 and lock=0, a fetch hits exactly when some way has both its valid bit and its match bit set. `hit_ways` marks those ways. A miss raises `ds_req` with `ds_single`=0, and a fill sets the valid bit of way `fill_way` in set `fill_idx` at the next edge.
- R5: With enable=1 and lock=1, hits behave as in R4. A miss raises `ds_req` with `ds_single`=1, and fills leave the valid bits unchanged.
- R6: Writing the flash bit (bit 2) while enable=1 clears every valid bit and returns bit 2 to 0 one edge after the write lands. While enable=0 the bit stays set and the valid bits are kept.
- R7: `binv_req` clears all ways of set `binv_idx` at the next edge, whatever the enable and lock state, and leaves the other sets unchanged.
- R8: In a cycle with `binv_req`, `inv_strobe` is all ones. With no fetch in that cycle, `ds_req` stays 0.
- R9: A fetch to the set being invalidated in that same cycle misses, while a fetch to another set is unaffected.
- R10: `cfg_wdata` is written when `cfg_we` is high, with bit 0 as enable, bit 1 as lock and bit 2 as flash. `cfg_rdata` reads back the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset of the configuration only |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Written value: {flash, lock, enable} |
| cfg_rdata | output | 3 | Current configuration: {flash, lock, enable} |
| fetch_req | input | 1 | Fetch request |
| fetch_idx | input | log2(SETS) | Set index of the fetch |
| fetch_match | input | WAYS | Per-way tag-match result from the external tag array |
| fetch_hit | output | 1 | Fetch is served by the cache |
| hit_ways | output | WAYS | Ways that are both valid and matching |
| ds_req | output | 1 | Fetch forwarded downstream |
| ds_single | output | 1 | The downstream fetch is a single-beat transfer |
| fill_req | input | 1 | Line fill complete; mark it valid |
| fill_idx | input | log2(SETS) | Set index of the fill |
| fill_way | input | log2(WAYS) | Way number of the fill |
| binv_req | input | 1 | Invalidate every way of one set |
| binv_idx | input | log2(SETS) | Set index to invalidate |
| inv_strobe | output | WAYS | Per-way valid-clear strobes for the set `binv_idx` |
| obs_idx | input | log2(SETS) | Set selected for observation |
| obs_valid | output | WAYS | Valid bits of set `obs_idx` |

## Verification
The bench builds the block with 4 ways and 8 sets. With that shape it can sweep every set and way and compare the whole valid array with a model after each phase. The fill pattern is computed from the set and way numbers. Each fetch sweep tries a single-way match on every way of every set, so every hit/miss combination is checked under the disabled, unlocked and locked modes. Set invalidation, flash and soft reset are each checked against the full array, so any stray clear or any missed clear shows up.

// File: rtl/icache_ctl.sv
module icache_ctl #(
  parameter int WAYS = 8,
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_wdata,
  output logic [2:0]       cfg_rdata,
  input  logic             fetch_req,
  input  logic [IDX_W-1:0] fetch_idx,
  input  logic [WAYS-1:0]  fetch_match,
  output logic             fetch_hit,
  output logic [WAYS-1:0]  hit_ways,
  output logic             ds_req,
  output logic             ds_single,
  input  logic             fill_req,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             binv_req,
  input  logic [IDX_W-1:0] binv_idx,
  output logic [WAYS-1:0]  inv_strobe,
  input  logic [IDX_W-1:0] obs_idx,
  output logic [WAYS-1:0]  obs_valid
);

  logic en_q, lk_q, fi_q;
  logic [WAYS-1:0] vld [SETS];

  logic clash, flash_now, fill_ok;

  assign flash_now = fi_q & en_q;
  assign fill_ok   = fill_req & en_q & ~lk_q;
  assign clash     = binv_req & (binv_idx == fetch_idx);

  assign cfg_rdata  = {fi_q, lk_q, en_q};
  assign hit_ways   = vld[fetch_idx] & fetch_match & {WAYS{fetch_req & en_q & ~clash}};
  assign fetch_hit  = |hit_ways;
  assign ds_req     = fetch_req & ~fetch_hit;
  assign ds_single  = ds_req & (~en_q | lk_q);
  assign inv_strobe = {WAYS{binv_req}};
  assign obs_valid  = vld[obs_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      lk_q <= 1'b0;
      fi_q <= 1'b0;
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (soft_rst) begin
      en_q <= 1'b0;
      lk_q <= 1'b0;
      fi_q <= 1'b0;
    end else begin
      if (cfg_we) {fi_q, lk_q, en_q} <= cfg_wdata;
      if (flash_now) begin
        if (!cfg_we) fi_q <= 1'b0;
        for (int s = 0; s < SETS; s++) vld[s] <= '0;
      end else begin
        if (fill_ok) vld[fill_idx][fill_way] <= 1'b1;
        if (binv_req) vld[binv_idx] <= '0;
      end
    end
  end

  a_r2_soft_clears_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_rdata == 3'b000));

  a_r3_disabled_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !cfg_rdata[0]) |-> (ds_req && ds_single && !fetch_hit));

  a_r5_locked_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && cfg_rdata[1]) |-> ds_single);

  a_r6_flash_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[2] && cfg_rdata[0] && !cfg_we && !soft_rst) |=> !cfg_rdata[2]);

  a_r7_set_emptied: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_req && !soft_rst) |=> (vld[$past(binv_idx)] == '0));

  a_r8_no_bus_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_req && !fetch_req) |-> (!ds_req && inv_strobe == {WAYS{1'b1}}));

  a_r9_same_set_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_req && fetch_req && binv_idx == fetch_idx) |-> !fetch_hit);

endmodule

// File: tb/icache_ctl_bench.sv
module icache_ctl_bench;
  localparam int WAYS = 4;
  localparam int SETS = 8;

  logic clk = 0, rst_n = 0, soft_rst = 0, cfg_we = 0;
  logic [2:0] cfg_wdata = 0, cfg_rdata;
  logic fetch_req = 0, fetch_hit, ds_req, ds_single;
  logic [2:0] fetch_idx = 0, fill_idx = 0, binv_idx = 0, obs_idx = 0;
  logic [3:0] fetch_match = 0, hit_ways, inv_strobe, obs_valid;
  logic fill_req = 0, binv_req = 0;
  logic [1:0] fill_way = 0;
  logic [3:0] exp_v [SETS];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  icache_ctl #(.WAYS(WAYS), .SETS(SETS)) u_icache_ctl (
    .clk, .rst_n, .soft_rst, .cfg_we, .cfg_wdata, .cfg_rdata,
    .fetch_req, .fetch_idx, .fetch_match, .fetch_hit, .hit_ways,
    .ds_req, .ds_single, .fill_req, .fill_idx, .fill_way,
    .binv_req, .binv_idx, .inv_strobe, .obs_idx, .obs_valid);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string req);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic chk_array(input string req);
    for (int s = 0; s < SETS; s++) begin
      obs_idx = 3'(s); #1;
      chk({4'd0, obs_valid}, {4'd0, exp_v[s]}, req);
    end
  endtask

  task automatic sweep(input logic en, input logic lk, input string req);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        logic h;
        fetch_req = 1; fetch_idx = 3'(s); fetch_match = 4'(1 << w); #1;
        h = en & exp_v[s][w];
        chk({7'd0, fetch_hit}, {7'd0, h}, req);
        chk({4'd0, hit_ways}, h ? {4'd0, 4'(1 << w)} : 8'd0, req);
        chk({6'd0, ds_req, ds_single}, h ? 8'd0 : {6'd0, 1'b1, ~en | lk}, req);
      end
    fetch_req = 0; fetch_match = 0;
  endtask

  task automatic wcfg(input logic [2:0] v);
    cfg_we = 1; cfg_wdata = v; tick(); cfg_we = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) exp_v[s] = 0;
    @(negedge clk); @(negedge clk);
    chk_array("R1 during reset");
    rst_n = 1; tick();
    chk({5'd0, cfg_rdata}, 8'd0, "R1 cfg");
    chk_array("R1 after reset");

    sweep(0, 0, "R3 disabled");
    fill_req = 1; fill_idx = 2; fill_way = 1; tick(); fill_req = 0;
    chk_array("R3 fill ignored");

    wcfg(3'b001);
    chk({5'd0, cfg_rdata}, 8'd1, "R10 enable readback");
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if ((s + w) % 3 != 0) begin
          fill_req = 1; fill_idx = 3'(s); fill_way = 2'(w); tick();
          exp_v[s][w] = 1;
        end
    fill_req = 0;
    chk_array("R4 fills");
    sweep(1, 0, "R4 unlocked");

    wcfg(3'b011);
    chk({5'd0, cfg_rdata}, 8'd3, "R10 lock readback");
    sweep(1, 1, "R5 locked");
    fill_req = 1; fill_idx = 0; fill_way = 0; tick(); fill_req = 0;
    chk_array("R5 fill refused");

    binv_req = 1; binv_idx = 3; #1;
    chk({4'd0, inv_strobe}, 8'h0F, "R8 strobe");
    chk({7'd0, ds_req}, 8'd0, "R8 no downstream");
    tick(); binv_req = 0; exp_v[3] = 0;
    chk_array("R7 locked set clear");

    wcfg(3'b001);
    binv_req = 1; binv_idx = 5; fetch_req = 1; fetch_idx = 5; fetch_match = 4'b0001; #1;
    chk({7'd0, fetch_hit}, 8'd0, "R9 same set miss");
    chk({7'd0, ds_req}, 8'd1, "R9 same set downstream");
    fetch_idx = 1; fetch_match = 4'b0001; #1;
    chk({7'd0, fetch_hit}, 8'd1, "R9 other set hit");
    tick(); binv_req = 0; fetch_req = 0; fetch_match = 0; exp_v[5] = 0;
    chk_array("R7 unlocked set clear");

    soft_rst = 1; tick(); soft_rst = 0;
    chk({5'd0, cfg_rdata}, 8'd0, "R2 cfg cleared");
    chk_array("R2 lines kept");

    binv_req = 1; binv_idx = 1; tick(); binv_req = 0; exp_v[1] = 0;
    chk_array("R7 disabled set clear");

    wcfg(3'b100);
    chk({5'd0, cfg_rdata}, 8'h4, "R6 flash held while disabled");
    tick();
    chk({5'd0, cfg_rdata}, 8'h4, "R6 flash still held");
    chk_array("R6 lines kept while disabled");
    wcfg(3'b101);
    chk({5'd0, cfg_rdata}, 8'h5, "R6 flash armed");
    tick();
    chk({5'd0, cfg_rdata}, 8'h1, "R6 flash self-cleared");
    for (int s = 0; s < SETS; s++) exp_v[s] = 0;
    chk_array("R6 all lines cleared");

    wcfg(3'b010);
    chk({5'd0, cfg_rdata}, 8'h2, "R10 lock only readback");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule